// File: doc/BRIEF.md
# RTC Alarm Matcher with Repeat Masks

This block watches a running BCD time of day (seconds, minutes, hours, day of month) that a separate timekeeper supplies. It compares that time against four programmable alarm bytes and raises a one-cycle interrupt pulse when they match. It evaluates the comparison only on the timekeeper's one-second strobe, so each matching second gives exactly one pulse.

Bit 7 of each alarm byte is a "don't care" flag for its field. The pattern of these four flags selects how often the alarm repeats: monthly, daily, hourly, once a minute or every second. A byte-wide register port gives software access to the four alarm bytes and to an enable register. Each alarm write is checked for a legal BCD value and is dropped if the value is illegal. The oscillator, the calendar counters and the host bus decode live elsewhere.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all four alarm bytes and the control register read 0x00, and `alarm_irq` is low.
- R2: Register slots are: 0 seconds alarm, 1 minutes alarm, 2 hours alarm, 3 date alarm, 4 control, with bit 0 = alarm enable. An alarm read returns the whole stored byte, including bit 7. A control read returns the enable in bit 0 and zeros above it. Slots 5 to 7 read 0x00 and ignore writes.
- R3: A seconds or minutes alarm write is stored (all 8 bits) only if bits [6:4] ≤ 5 and bits [3:0] ≤ 9. Any other write leaves the byte unchanged.
- R4: An hours alarm write is stored only if bits [5:4] and [3:0] form a BCD value from 00 to 23. Any other write leaves the byte unchanged.
- R5: A date alarm write is stored only if bits [5:0] form a non-zero BCD value (units ≤ 9). Any other write leaves the byte unchanged.
- R6: With all four flag bits clear, a strobe fires when date, hour, minute and second all match. Seconds and minutes are compared on bits [6:0]; hours and date are compared on bits [5:0].
- R7: With only the date flag set, a strobe fires when hour, minute and second match, whatever the date.
- R8: With the date and hour flags set and the others clear, a strobe fires when minute and second match.
- R9: With the date, hour and minute flags set and the seconds flag clear, a strobe fires when the seconds match.
- R10: Any other flag pattern, including all four set, fires on every strobe.
- R11: `alarm_irq` is high for exactly the one cycle that follows a firing strobe. It is never high without a strobe in the cycle before.
- R12: While the enable bit is 0, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register slot select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected slot (combinational) |
| tick | input | 1 | One-second strobe from the timekeeper |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
The pulse properties assume that `tick` is high for one cycle and never on two cycles in a row, as a one-second strobe always is. The stimulus therefore follows every strobe with an idle cycle. The write-acceptance properties assume that writes begin only after the internal reset has been released. The bench waits several cycles after deasserting `rst_n` before it drives any traffic. The time-of-day inputs are held steady from one strobe to the next, so each match decision depends only on the values present at that strobe.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 4;
  localparam int SEC_W      = 7;
  localparam int HOUR_W     = 6;

  // field slots; the slot number is also the register address
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DATE = 3;

  localparam int CTRL_SLOT   = 4;
  localparam int CTRL_EN_BIT = 0;
  localparam int MASK_BIT    = 7;

  typedef enum logic [2:0] {
    RPT_MONTH  = 3'd0,
    RPT_DAY    = 3'd1,
    RPT_HOUR   = 3'd2,
    RPT_MINUTE = 3'd3,
    RPT_SECOND = 3'd4
  } rpt_mode_e;

  // BCD legality of a byte written to alarm field idx (R3, R4, R5)
  function automatic logic field_write_ok(input int idx, input logic [BYTE_W-1:0] v);
    logic units_ok;
    units_ok = (v[3:0] <= 4'd9);
    case (idx)
      FLD_SEC, FLD_MIN: return units_ok && (v[6:4] <= 3'd5);
      FLD_HOUR:         return units_ok && (v[5:0] <= 6'h23);
      FLD_DATE:         return units_ok && (v[5:0] != 6'h00);
      default:          return 1'b0;
    endcase
  endfunction

  // bits of a field that take part in the time comparison
  function automatic logic [BYTE_W-1:0] field_cmp_mask(input int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 8'h7F;
      default:          return 8'h3F;
    endcase
  endfunction

  // fields that must match for a given repeat rate
  function automatic logic [NUM_FIELDS-1:0] needed_fields(input rpt_mode_e m);
    case (m)
      RPT_MONTH:  return 4'b1111;
      RPT_DAY:    return 4'b0111;
      RPT_HOUR:   return 4'b0011;
      RPT_MINUTE: return 4'b0001;
      default:    return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 reg_we,
  input  logic [ADDR_W-1:0]                    reg_addr,
  input  logic [BYTE_W-1:0]                    reg_wdata,
  output logic [BYTE_W-1:0]                    reg_rdata,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]    alm_q,
  output logic                                 irq_en
);

  localparam int IDX_W = $clog2(NUM_FIELDS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(CTRL_SLOT);
  localparam logic [ADDR_W-1:0] FIELD_LIM  = ADDR_W'(NUM_FIELDS);

  // one validated byte register per alarm field
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic              sel;
    logic              ce;
    logic [BYTE_W-1:0] d;
    logic [BYTE_W-1:0] q;

    always_comb begin
      sel = reg_we && (reg_addr == ADDR_W'(i));
      ce  = sel && field_write_ok(i, reg_wdata);
      d   = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ce) begin
        q <= d;
      end
    end

    assign alm_q[i] = q;
  end

  // control register: alarm enable
  logic en_ce;
  logic en_d;

  always_comb begin
    en_ce = reg_we && (reg_addr == CTRL_ADDR);
    en_d  = reg_wdata[CTRL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
    end else if (en_ce) begin
      irq_en <= en_d;
    end
  end

  // read multiplexer
  always_comb begin
    reg_rdata = '0;
    if (reg_addr < FIELD_LIM) begin
      reg_rdata = alm_q[reg_addr[IDX_W-1:0]];
    end else if (reg_addr == CTRL_ADDR) begin
      reg_rdata = {{(BYTE_W-1){1'b0}}, irq_en};
    end
  end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_q,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] tod_v,
  output rpt_mode_e                         mode,
  output logic                              hit
);

  logic [NUM_FIELDS-1:0] eq;
  logic [NUM_FIELDS-1:0] flag;
  logic [NUM_FIELDS-1:0] need;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    always_comb begin
      eq[i]   = (((alm_q[i] ^ tod_v[i]) & field_cmp_mask(i)) == '0);
      flag[i] = alm_q[i][MASK_BIT];
    end
  end

  // flag pattern {date, hour, min, sec} selects the repeat rate
  always_comb begin
    case ({flag[FLD_DATE], flag[FLD_HOUR], flag[FLD_MIN], flag[FLD_SEC]})
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    need = needed_fields(mode);
    hit  = &(eq | ~need);
  end

endmodule

// File: rtl/rtc_alarm_pulse.sv
module rtc_alarm_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic irq_en,
  output logic irq
);

  logic irq_d;

  always_comb begin
    irq_d = tick && hit && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [SEC_W-1:0]  tod_min,
  input  logic [HOUR_W-1:0] tod_hour,
  input  logic [HOUR_W-1:0] tod_date,
  output logic              alarm_irq
);

  logic                              rst_sync_n;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_q;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] tod_v;
  logic                              irq_en;
  logic                              hit;
  rpt_mode_e                         mode;

  rtc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rtc_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .alm_q     (alm_q),
    .irq_en    (irq_en)
  );

  always_comb begin
    tod_v[FLD_SEC]  = BYTE_W'(tod_sec);
    tod_v[FLD_MIN]  = BYTE_W'(tod_min);
    tod_v[FLD_HOUR] = BYTE_W'(tod_hour);
    tod_v[FLD_DATE] = BYTE_W'(tod_date);
  end

  rtc_alarm_cmp u_cmp (
    .alm_q (alm_q),
    .tod_v (tod_v),
    .mode  (mode),
    .hit   (hit)
  );

  rtc_alarm_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .hit    (hit),
    .irq_en (irq_en),
    .irq    (alarm_irq)
  );

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              tick,
  input logic                              reg_we,
  input logic [ADDR_W-1:0]                 reg_addr,
  input logic [BYTE_W-1:0]                 reg_wdata,
  input logic                              alarm_irq,
  input logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_q,
  input logic                              irq_en
);

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(FLD_SEC);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(FLD_HOUR);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(FLD_DATE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_SLOT);

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(tick)); // R11

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |=> !alarm_irq); // R11

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(irq_en)); // R12

  AST_SEC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SEC && reg_wdata[6:4] <= 3'd5 && reg_wdata[3:0] <= 4'd9)
    |=> (alm_q[FLD_SEC] == $past(reg_wdata))); // R3

  AST_SEC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SEC && (reg_wdata[6:4] > 3'd5 || reg_wdata[3:0] > 4'd9))
    |=> $stable(alm_q[FLD_SEC])); // R3

  AST_HOUR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_HOUR && (reg_wdata[5:0] > 6'h23 || reg_wdata[3:0] > 4'd9))
    |=> $stable(alm_q[FLD_HOUR])); // R4

  AST_DATE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DATE && reg_wdata[5:0] == 6'h00)
    |=> $stable(alm_q[FLD_DATE])); // R5

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr > A_CTRL) |=> ($stable(alm_q) && $stable(irq_en))); // R2

  AST_EVERY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && irq_en && alm_q[FLD_SEC][MASK_BIT] && alm_q[FLD_MIN][MASK_BIT]
     && alm_q[FLD_HOUR][MASK_BIT] && alm_q[FLD_DATE][MASK_BIT]) |=> alarm_irq); // R10

endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick      (tick),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .alarm_irq (alarm_irq),
  .alm_q     (alm_q),
  .irq_en    (irq_en)
);

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;

  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tick;
  logic [6:0] tod_sec;
  logic [6:0] tod_min;
  logic [5:0] tod_hour;
  logic [5:0] tod_date;
  logic       alarm_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    bit       chk_rd;
    bit [7:0] rd_exp;
    bit       irq_exp;
    string    tag;
  } item_t;

  item_t sb_q[$];

  rtc_alarm_match uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tick      (tick),
    .tod_sec   (tod_sec),
    .tod_min   (tod_min),
    .tod_hour  (tod_hour),
    .tod_date  (tod_date),
    .alarm_irq (alarm_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: each driven cycle is checked 2 ns after the following rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (alarm_irq !== it.irq_exp) begin
          n_fail++;
          $display("FAIL %s: alarm_irq=%b expected %b", it.tag, alarm_irq, it.irq_exp);
        end
        if (it.chk_rd) begin
          n_checks++;
          if (reg_rdata !== it.rd_exp) begin
            n_fail++;
            $display("FAIL %s: reg_rdata=%h expected %h", it.tag, reg_rdata, it.rd_exp);
          end
        end
      end
    end
  end

  task automatic push(input bit chk_rd, input bit [7:0] rd_exp, input bit irq_exp, input string tag);
    item_t it;
    it.chk_rd  = chk_rd;
    it.rd_exp  = rd_exp;
    it.irq_exp = irq_exp;
    it.tag     = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d, input string tag);
    @(negedge clk);
    tick      = 1'b0;
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    push(1'b0, 8'h00, 1'b0, {tag, " (write, R11 idle)"});
  endtask

  task automatic rd(input bit [2:0] a, input bit [7:0] exp, input string tag);
    @(negedge clk);
    tick     = 1'b0;
    reg_we   = 1'b0;
    reg_addr = a;
    push(1'b1, exp, 1'b0, tag);
  endtask

  task automatic tk(input bit [6:0] s, input bit [6:0] m, input bit [5:0] h,
                    input bit [5:0] d, input bit exp, input string tag);
    @(negedge clk);
    reg_we   = 1'b0;
    tick     = 1'b1;
    tod_sec  = s;
    tod_min  = m;
    tod_hour = h;
    tod_date = d;
    push(1'b0, 8'h00, exp, tag);
    @(negedge clk);
    tick = 1'b0;
    push(1'b0, 8'h00, 1'b0, {tag, " pulse ends R11"});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    tick      = 1'b0;
    tod_sec   = '0;
    tod_min   = '0;
    tod_hour  = '0;
    tod_date  = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, 8'h00, "R1 sec alarm after reset");
    rd(3'd1, 8'h00, "R1 min alarm after reset");
    rd(3'd2, 8'h00, "R1 hour alarm after reset");
    rd(3'd3, 8'h00, "R1 date alarm after reset");
    rd(3'd4, 8'h00, "R1 control after reset");

    // R3 seconds
    wr(3'd0, 8'h45, "R3 sec 45");
    rd(3'd0, 8'h45, "R3 sec 45 stored");
    wr(3'd0, 8'h5A, "R3 sec bad units");
    rd(3'd0, 8'h45, "R3 sec bad units rejected");
    wr(3'd0, 8'h60, "R3 sec bad tens");
    rd(3'd0, 8'h45, "R3 sec 60 rejected");
    wr(3'd0, 8'hD9, "R2 sec with flag");
    rd(3'd0, 8'hD9, "R2 read returns flag bit");
    wr(3'd0, 8'h30, "R3 sec 30");
    rd(3'd0, 8'h30, "R3 sec 30 stored");

    // R3 minutes
    wr(3'd1, 8'h59, "R3 min 59");
    rd(3'd1, 8'h59, "R3 min 59 stored");
    wr(3'd1, 8'h7F, "R3 min bad");
    rd(3'd1, 8'h59, "R3 min 7F rejected");
    wr(3'd1, 8'h15, "R3 min 15");
    rd(3'd1, 8'h15, "R3 min 15 stored");

    // R4 hours
    wr(3'd2, 8'h24, "R4 hour 24");
    rd(3'd2, 8'h00, "R4 hour 24 rejected");
    wr(3'd2, 8'h23, "R4 hour 23");
    rd(3'd2, 8'h23, "R4 hour 23 stored");
    wr(3'd2, 8'h1A, "R4 hour bad units");
    rd(3'd2, 8'h23, "R4 hour 1A rejected");
    wr(3'd2, 8'h30, "R4 hour 30");
    rd(3'd2, 8'h23, "R4 hour 30 rejected");
    wr(3'd2, 8'h08, "R4 hour 08");
    rd(3'd2, 8'h08, "R4 hour 08 stored");

    // R5 date
    wr(3'd3, 8'h31, "R5 date 31");
    rd(3'd3, 8'h31, "R5 date 31 stored");
    wr(3'd3, 8'h00, "R5 date zero");
    rd(3'd3, 8'h31, "R5 date zero rejected");
    wr(3'd3, 8'h40, "R5 date zero low bits");
    rd(3'd3, 8'h31, "R5 date 40 rejected");
    wr(3'd3, 8'h2B, "R5 date bad units");
    rd(3'd3, 8'h31, "R5 date 2B rejected");
    wr(3'd3, 8'h12, "R5 date 12");
    rd(3'd3, 8'h12, "R5 date 12 stored");

    // R2 unmapped slots and control
    wr(3'd5, 8'hAA, "R2 unmapped write");
    rd(3'd5, 8'h00, "R2 slot 5 reads zero");
    rd(3'd7, 8'h00, "R2 slot 7 reads zero");
    rd(3'd0, 8'h30, "R2 sec untouched by slot 5");
    rd(3'd3, 8'h12, "R2 date untouched by slot 5");
    rd(3'd4, 8'h00, "R2 control untouched by slot 5");
    wr(3'd4, 8'hFF, "R2 enable");
    rd(3'd4, 8'h01, "R2 control reads enable only");

    // R6 monthly: 12th 08:15:30
    tk(7'h30, 7'h15, 6'h08, 6'h12, 1'b1, "R6 full match");
    tk(7'h30, 7'h15, 6'h08, 6'h13, 1'b0, "R6 date differs");
    tk(7'h31, 7'h15, 6'h08, 6'h12, 1'b0, "R6 seconds differ");

    // R7 daily
    wr(3'd3, 8'h92, "R7 date flag");
    tk(7'h30, 7'h15, 6'h08, 6'h05, 1'b1, "R7 other date fires");
    tk(7'h30, 7'h15, 6'h09, 6'h05, 1'b0, "R7 hour differs");

    // R8 hourly
    wr(3'd2, 8'h88, "R8 hour flag");
    tk(7'h30, 7'h15, 6'h17, 6'h01, 1'b1, "R8 other hour fires");
    tk(7'h30, 7'h16, 6'h17, 6'h01, 1'b0, "R8 minute differs");

    // R9 once a minute
    wr(3'd1, 8'h95, "R9 minute flag");
    tk(7'h30, 7'h44, 6'h03, 6'h07, 1'b1, "R9 other minute fires");
    tk(7'h29, 7'h44, 6'h03, 6'h07, 1'b0, "R9 seconds differ");

    // R10 every second
    wr(3'd0, 8'hB0, "R10 all flags");
    tk(7'h01, 7'h02, 6'h03, 6'h04, 1'b1, "R10 all flags fire");
    wr(3'd3, 8'h12, "R10 date flag cleared");
    tk(7'h00, 7'h00, 6'h00, 6'h01, 1'b1, "R10 odd pattern fires");

    // R12 enable gating
    wr(3'd4, 8'h00, "R12 disable");
    rd(3'd4, 8'h00, "R12 control cleared");
    tk(7'h05, 7'h06, 6'h07, 6'h08, 1'b0, "R12 no pulse when disabled");
    wr(3'd4, 8'h01, "R12 re-enable");
    tk(7'h05, 7'h06, 6'h07, 6'h08, 1'b1, "R12 pulse after re-enable");

    repeat (3) @(negedge clk);
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule